// File: doc/BRIEF.md
# LPC TPM-Cycle Target Interface

This block is the bus-facing end of a security module attached to a host over the 4-bit LPC address/data bus. It watches the framing signal and the nibble bus and takes part only in TPM-type transfers. Each such transfer carries one byte, and its 16-bit address names a locality in the top nibble. Every other kind of bus traffic passes by without the block ever driving the bus.

For each TPM transfer it recognises, the block shifts in the address and, for a write, the data byte. It then asks an external access-control function whether the access is allowed. An allowed access is handed to the register side as a held request. The block stretches the bus with long-wait sync codes until the register side reports ready, and then finishes with an OK sync. A refused access, or one whose locality is not decoded, gets no sync at all, so the host sees a master abort and no register sees the request. Pulling the framing signal low at any point cancels the transfer in progress.

Top module: `lpc_tpm_target`

## Requirements
- R1: After a synchronous active-low reset the block does not drive the bus (`lad_oe` low) and raises no register request.
- R2: A transfer is taken only when nibble 0101 is seen with `lframe_n` low, followed by direction nibble 0000 (read) or 0010 (write). Any other start nibble, any other direction nibble, and any nibble seen while `lframe_n` is high outside a transfer leave the bus undriven and raise no request.
- R3: The four address nibbles arrive most significant first. `reg_loc` presents address bits [15:12] and `reg_ofs` presents bits [11:0] while the request is raised.
- R4: The write data byte arrives low nibble first and is presented on `reg_wdata` while the request is raised. `reg_we` is high for writes and low for reads.
- R5: In every sync clock in which `reg_ready` is low, the block drives 0110 (long wait) and holds `reg_req` high.
- R6: In the sync clock in which `reg_ready` is high, the block drives 0000 (OK). No other code is ever driven during sync.
- R7: After OK on a read, the block drives `reg_rdata` (as sampled in the OK clock) over two clocks, low nibble first.
- R8: After its last driven phase the block drives 1111 for one clock and then releases the bus.
- R9: When `acc_ok` is low in the last host-turnaround clock, the block drives no sync, raises no request and leaves the bus undriven.
- R10: An address whose bits [15:12] exceed 4 is not decoded and is dropped exactly like a refused access, even when `acc_ok` is high.
- R11: `lframe_n` low in the middle of a transfer releases the bus and drops the request in that same clock. If the nibble in that clock is 0101, it starts a new transfer.
- R12: During the two host-turnaround clocks that follow the host's last nibble, the block does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lframe_n | input | 1 | Active-low frame / abort indication |
| lad_in | input | 4 | Nibble bus as received |
| lad_out | output | 4 | Nibble the block drives |
| lad_oe | output | 1 | Output enable for `lad_out` |
| reg_req | output | 1 | Register access request, held until ready |
| reg_we | output | 1 | 1 = write access, 0 = read access |
| reg_loc | output | 4 | Locality taken from address [15:12] |
| reg_ofs | output | 12 | Offset taken from address [11:0] |
| reg_wdata | output | 8 | Write byte |
| reg_rdata | input | 8 | Read byte, sampled in the ready clock |
| reg_ready | input | 1 | Register side has finished the access |
| acc_ok | input | 1 | Access-control verdict for the presented address and direction |

## Verification
The bench runs reads and writes through several localities and offsets, with zero, one and several wait clocks. These runs separate the long-wait code from the OK code and confirm that the read data and write data nibbles come out in the right order. Refused accesses and accesses to locality 7 are run to show that both end with a silent bus rather than a sync. Non-TPM start nibbles, an unknown direction code, and a start pattern seen while framing is high are run to show they cause no response. Two abort cases complete the set: an abort that carries a new start during the address phase, which must resume as a fresh transfer, and a plain abort during a wait, which must release the bus at once.

// File: rtl/lpc_tpm_pkg.sv
// Shared encodings and state type for the LPC TPM-cycle target.
package lpc_tpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC,
        ST_RDATA,
        ST_TTAR
    } lpc_state_e;

    localparam logic [3:0] NIB_START_TPM  = 4'b0101;
    localparam logic [3:0] NIB_DIR_RD     = 4'b0000;
    localparam logic [3:0] NIB_DIR_WR     = 4'b0010;
    localparam logic [3:0] NIB_SYNC_OK    = 4'b0000;
    localparam logic [3:0] NIB_SYNC_LWAIT = 4'b0110;
    localparam logic [3:0] NIB_TAR        = 4'b1111;
endpackage

// File: rtl/lpc_cycle_fsm.sv
// Phase sequencer for one LPC TPM transfer.
// Assumes: grant is valid in the last host-turnaround clock; a low
// lframe_n in any state restarts start detection.
module lpc_cycle_fsm
    import lpc_tpm_pkg::*;
#(
    parameter int ADDR_NIBBLES = 4,
    parameter int DATA_NIBBLES = 2,
    parameter int TAR_CLKS     = 2,
    parameter int CNT_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lframe_n,
    input  logic [3:0]       lad_in,
    input  logic             grant,
    input  logic             reg_ready,
    output lpc_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic             we,
    output logic             cnt_last
);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_NIBBLES - 1);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_NIBBLES - 1);
    localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TAR_CLKS - 1);

    lpc_state_e       nxt_st;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_we;

    // Last-count flag for the phase currently running.
    always_comb begin
        case (st)
            ST_ADDR:            cnt_last = (cnt == A_LAST);
            ST_WDATA, ST_RDATA: cnt_last = (cnt == D_LAST);
            ST_HTAR, ST_TTAR:   cnt_last = (cnt == T_LAST);
            default:            cnt_last = 1'b1;
        endcase
    end

    // Next-phase decision.
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt_last ? '0 : cnt + 1'b1;
        nxt_we  = we;
        if (!lframe_n) begin
            nxt_cnt = '0;
            nxt_st  = (lad_in == NIB_START_TPM) ? ST_CTYPE : ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  nxt_cnt = '0;
                ST_CTYPE: begin
                    nxt_cnt = '0;
                    if (lad_in == NIB_DIR_RD) begin
                        nxt_st = ST_ADDR;
                        nxt_we = 1'b0;
                    end else if (lad_in == NIB_DIR_WR) begin
                        nxt_st = ST_ADDR;
                        nxt_we = 1'b1;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end
                ST_ADDR:  if (cnt_last) nxt_st = we ? ST_WDATA : ST_HTAR;
                ST_WDATA: if (cnt_last) nxt_st = ST_HTAR;
                ST_HTAR:  if (cnt_last) nxt_st = grant ? ST_SYNC : ST_IDLE;
                ST_SYNC: begin
                    nxt_cnt = '0;
                    if (reg_ready) nxt_st = we ? ST_TTAR : ST_RDATA;
                end
                ST_RDATA: if (cnt_last) nxt_st = ST_TTAR;
                ST_TTAR:  if (cnt_last) nxt_st = ST_IDLE;
                default:  nxt_st = ST_IDLE;
            endcase
        end
    end

    // State, counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            we  <= 1'b0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
            we  <= nxt_we;
        end
    end
endmodule

// File: rtl/lpc_field_capture.sv
// Collects address and write nibbles from the bus and holds the read byte.
// Assumes: address is MSB nibble first, data is low nibble first.
module lpc_field_capture
    import lpc_tpm_pkg::*;
#(
    parameter int ADDR_NIBBLES = 4,
    parameter int DATA_NIBBLES = 2,
    parameter int CNT_W        = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lpc_state_e                st,
    input  logic [CNT_W-1:0]          cnt,
    input  logic                      lframe_n,
    input  logic [3:0]                lad_in,
    input  logic                      rd_take,
    input  logic [DATA_NIBBLES*4-1:0] rd_in,
    output logic [ADDR_NIBBLES*4-1:0] addr_q,
    output logic [DATA_NIBBLES*4-1:0] wdata_q,
    output logic [DATA_NIBBLES*4-1:0] rdata_q
);
    localparam int ADDR_W = ADDR_NIBBLES * 4;

    // Address shift register, MSB nibble enters first.
    always_ff @(posedge clk) begin
        if (!rst_n)                             addr_q <= '0;
        else if (lframe_n && st == ST_ADDR)     addr_q <= {addr_q[ADDR_W-5:0], lad_in};
    end

    // One slot per write nibble, filled in arrival order.
    for (genvar g = 0; g < DATA_NIBBLES; g++) begin : g_wnib
        always_ff @(posedge clk) begin
            if (!rst_n)
                wdata_q[g*4 +: 4] <= '0;
            else if (lframe_n && st == ST_WDATA && cnt == CNT_W'(g))
                wdata_q[g*4 +: 4] <= lad_in;
        end
    end

    // Read byte latched in the OK clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_take) rdata_q <= rd_in;
    end
endmodule

// File: rtl/lpc_lad_driver.sv
// Selects the nibble and enable the target puts on the bus.
// Assumes: the bus is released at once when lframe_n is low.
module lpc_lad_driver
    import lpc_tpm_pkg::*;
#(
    parameter int DATA_NIBBLES = 2,
    parameter int CNT_W        = 2
) (
    input  lpc_state_e                st,
    input  logic [CNT_W-1:0]          cnt,
    input  logic                      lframe_n,
    input  logic                      reg_ready,
    input  logic [DATA_NIBBLES*4-1:0] rdata_q,
    output logic [3:0]                lad_out,
    output logic                      lad_oe
);
    // Drive value and enable per phase.
    always_comb begin
        lad_out = NIB_TAR;
        lad_oe  = 1'b0;
        case (st)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = reg_ready ? NIB_SYNC_OK : NIB_SYNC_LWAIT;
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = rdata_q[4*int'(cnt) +: 4];
            end
            ST_TTAR: lad_oe = (cnt == '0);
            default: lad_oe = 1'b0;
        endcase
        if (!lframe_n) lad_oe = 1'b0;
    end
endmodule

// File: rtl/lpc_tpm_target.sv
// LPC target servicing TPM-type single-byte transfers.
// Assumes: acc_ok is a function of reg_loc/reg_ofs/reg_we from the
// access-control logic; reg_rdata is valid when reg_ready is high.
module lpc_tpm_target
    import lpc_tpm_pkg::*;
#(
    parameter int ADDR_NIBBLES = 4,
    parameter int DATA_W       = 8,
    parameter int LOC_BITS     = 4,
    parameter int LOC_MAX      = 4,
    parameter int TAR_CLKS     = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             lframe_n,
    input  logic [3:0]                       lad_in,
    output logic [3:0]                       lad_out,
    output logic                             lad_oe,
    output logic                             reg_req,
    output logic                             reg_we,
    output logic [LOC_BITS-1:0]              reg_loc,
    output logic [ADDR_NIBBLES*4-LOC_BITS-1:0] reg_ofs,
    output logic [DATA_W-1:0]                reg_wdata,
    input  logic [DATA_W-1:0]                reg_rdata,
    input  logic                             reg_ready,
    input  logic                             acc_ok
);
    localparam int ADDR_W       = ADDR_NIBBLES * 4;
    localparam int DATA_NIBBLES = DATA_W / 4;
    localparam int MAXN_A       = (ADDR_NIBBLES > DATA_NIBBLES) ? ADDR_NIBBLES : DATA_NIBBLES;
    localparam int MAXN         = (MAXN_A > TAR_CLKS) ? MAXN_A : TAR_CLKS;
    localparam int CNT_W        = (MAXN < 2) ? 1 : $clog2(MAXN);

    lpc_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_last;
    logic              loc_ok;
    logic              grant;
    logic              rd_take;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;

    // Locality decode and combined acceptance verdict.
    always_comb begin
        loc_ok = (addr_q[ADDR_W-1 -: LOC_BITS] <= LOC_BITS'(LOC_MAX));
        grant  = loc_ok && acc_ok;
    end

    // Request held through sync; read byte taken in the OK clock.
    always_comb begin
        reg_req = (st_q == ST_SYNC) && lframe_n;
        rd_take = reg_req && reg_ready;
        reg_loc = addr_q[ADDR_W-1 -: LOC_BITS];
        reg_ofs = addr_q[ADDR_W-LOC_BITS-1:0];
    end

    lpc_cycle_fsm #(
        .ADDR_NIBBLES(ADDR_NIBBLES), .DATA_NIBBLES(DATA_NIBBLES),
        .TAR_CLKS(TAR_CLKS), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .grant(grant), .reg_ready(reg_ready),
        .st(st_q), .cnt(cnt_q), .we(reg_we), .cnt_last(cnt_last)
    );

    lpc_field_capture #(
        .ADDR_NIBBLES(ADDR_NIBBLES), .DATA_NIBBLES(DATA_NIBBLES), .CNT_W(CNT_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .st(st_q), .cnt(cnt_q), .lframe_n(lframe_n),
        .lad_in(lad_in), .rd_take(rd_take), .rd_in(reg_rdata),
        .addr_q(addr_q), .wdata_q(reg_wdata), .rdata_q(rdata_q)
    );

    lpc_lad_driver #(
        .DATA_NIBBLES(DATA_NIBBLES), .CNT_W(CNT_W)
    ) u_drv (
        .st(st_q), .cnt(cnt_q), .lframe_n(lframe_n), .reg_ready(reg_ready),
        .rdata_q(rdata_q), .lad_out(lad_out), .lad_oe(lad_oe)
    );
endmodule

// File: rtl/lpc_tpm_target_chk.sv
// Property checker for lpc_tpm_target, attached by bind.
module lpc_tpm_target_chk
    import lpc_tpm_pkg::*;
#(
    parameter int LOC_BITS = 4,
    parameter int LOC_MAX  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lframe_n,
    input logic                lad_oe,
    input logic [3:0]          lad_out,
    input logic                reg_req,
    input logic                reg_ready,
    input logic                acc_ok,
    input logic [LOC_BITS-1:0] reg_loc,
    input lpc_state_e          st_q,
    input logic                cnt_last
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!lad_oe && !reg_req));

    assert_wait_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ready) |-> (lad_oe && lad_out == NIB_SYNC_LWAIT));

    assert_ok_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ready) |-> (lad_oe && lad_out == NIB_SYNC_OK));

    assert_refuse_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HTAR && cnt_last && lframe_n && !acc_ok) |=> (!lad_oe && !reg_req));

    assert_loc_decoded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (reg_loc <= LOC_BITS'(LOC_MAX)));

    assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |-> (!lad_oe && !reg_req));

    assert_host_tar_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HTAR) |-> !lad_oe);
endmodule

bind lpc_tpm_target lpc_tpm_target_chk #(.LOC_BITS(LOC_BITS), .LOC_MAX(LOC_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_oe(lad_oe), .lad_out(lad_out),
    .reg_req(reg_req), .reg_ready(reg_ready), .acc_ok(acc_ok), .reg_loc(reg_loc),
    .st_q(st_q), .cnt_last(cnt_last)
);

// File: tb/lpc_tpm_target_bench.sv
// Scoreboard bench: the driver queues per-clock expectations, the monitor compares.
module lpc_tpm_target_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        reg_req;
    logic        reg_we;
    logic [3:0]  reg_loc;
    logic [11:0] reg_ofs;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata = 8'h00;
    logic        reg_ready = 1'b0;
    logic        acc_ok = 1'b1;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic        oe;
        logic [3:0]  out;
        logic        req;
        logic        chk_reg;
        logic [3:0]  loc;
        logic [11:0] ofs;
        logic        we;
        logic [7:0]  wd;
        string       tag;
    } exp_t;

    exp_t expq[$];

    logic        pend_chk = 1'b0;
    logic [3:0]  pend_loc;
    logic [11:0] pend_ofs;
    logic        pend_we;
    logic [7:0]  pend_wd;

    always #2 clk = ~clk;

    lpc_tpm_target u_lpc_tpm_target (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .reg_req(reg_req), .reg_we(reg_we),
        .reg_loc(reg_loc), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready), .acc_ok(acc_ok)
    );

    // One bus clock: drive inputs at the falling edge and queue the expectation.
    task automatic tick(input logic fr, input logic [3:0] nib, input logic rdy,
                        input logic eoe, input logic [3:0] eout, input logic ereq,
                        input string tag);
        exp_t it;
        @(negedge clk);
        lframe_n  = fr;
        lad_in    = nib;
        reg_ready = rdy;
        it.oe = eoe; it.out = eout; it.req = ereq;
        it.chk_reg = pend_chk; it.loc = pend_loc; it.ofs = pend_ofs;
        it.we = pend_we; it.wd = pend_wd; it.tag = tag;
        pend_chk = 1'b0;
        expq.push_back(it);
    endtask

    // Full TPM transfer with the expected target response.
    task automatic tpm_cycle(input bit do_start, input bit wr, input logic [15:0] a,
                             input logic [7:0] wd, input bit grant, input int waits,
                             input logic [7:0] rd);
        bit served;
        served    = grant && (a[15:12] <= 4'd4);
        acc_ok    = grant;
        reg_rdata = rd;
        if (do_start) tick(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R2 start");
        tick(1'b1, wr ? 4'h2 : 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R2 direction");
        for (int i = 3; i >= 0; i--)
            tick(1'b1, a[i*4 +: 4], 1'b0, 1'b0, 4'h0, 1'b0, "R3 address nibble");
        if (wr) begin
            tick(1'b1, wd[3:0], 1'b0, 1'b0, 4'h0, 1'b0, "R4 data low");
            tick(1'b1, wd[7:4], 1'b0, 1'b0, 4'h0, 1'b0, "R4 data high");
        end
        for (int t = 0; t < 2; t++)
            tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R12 host turnaround");
        if (served) begin
            for (int w = 0; w < waits; w++)
                tick(1'b1, 4'hF, 1'b0, 1'b1, 4'h6, 1'b1, "R5 long wait");
            pend_chk = 1'b1; pend_loc = a[15:12]; pend_ofs = a[11:0];
            pend_we = wr; pend_wd = wd;
            tick(1'b1, 4'hF, 1'b1, 1'b1, 4'h0, 1'b1, "R6 sync ok, R3 R4 fields");
            if (!wr) begin
                tick(1'b1, 4'hF, 1'b0, 1'b1, rd[3:0], 1'b0, "R7 read low nibble");
                tick(1'b1, 4'hF, 1'b0, 1'b1, rd[7:4], 1'b0, "R7 read high nibble");
            end
            tick(1'b1, 4'hF, 1'b0, 1'b1, 4'hF, 1'b0, "R8 turnaround drive");
            tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R8 turnaround release");
        end else begin
            for (int k = 0; k < 3; k++)
                tick(1'b1, 4'hF, 1'b1, 1'b0, 4'h0, 1'b0,
                     (a[15:12] > 4'd4) ? "R10 undecoded locality" : "R9 refused");
        end
        tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R1 idle between cycles");
    endtask

    // Monitor: compare outputs just after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t it;
                it = expq.pop_front();
                compared++;
                if (lad_oe !== it.oe || reg_req !== it.req || (it.oe && lad_out !== it.out)) begin
                    mismatched++;
                    $display("FAIL %s: oe=%0b out=%h req=%0b expected oe=%0b out=%h req=%0b",
                             it.tag, lad_oe, lad_out, reg_req, it.oe, it.out, it.req);
                end
                if (it.chk_reg) begin
                    compared++;
                    if (reg_loc !== it.loc || reg_ofs !== it.ofs || reg_we !== it.we ||
                        (it.we && reg_wdata !== it.wd)) begin
                        mismatched++;
                        $display("FAIL R3/R4 %s: loc=%h ofs=%h we=%0b wd=%h expected loc=%h ofs=%h we=%0b wd=%h",
                                 it.tag, reg_loc, reg_ofs, reg_we, reg_wdata,
                                 it.loc, it.ofs, it.we, it.wd);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        mismatched++;
        $display("FAIL watchdog: run state=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R1 reset state");
        tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R1 reset state");

        // Writes and reads across localities and wait counts.
        tpm_cycle(1'b1, 1'b1, 16'h0024, 8'hA5, 1'b1, 0, 8'h00);
        tpm_cycle(1'b1, 1'b0, 16'h1F18, 8'h00, 1'b1, 1, 8'h3C);
        tpm_cycle(1'b1, 1'b1, 16'h4ABC, 8'h96, 1'b1, 3, 8'h00);
        tpm_cycle(1'b1, 1'b0, 16'h3000, 8'h00, 1'b1, 0, 8'hE7);
        tpm_cycle(1'b1, 1'b0, 16'h2FFE, 8'h00, 1'b1, 5, 8'h81);

        // Refused write and read, and an undecoded locality.
        tpm_cycle(1'b1, 1'b1, 16'h0018, 8'h55, 1'b0, 0, 8'h00);
        tpm_cycle(1'b1, 1'b0, 16'h0F00, 8'h00, 1'b0, 0, 8'h12);
        tpm_cycle(1'b1, 1'b0, 16'h7004, 8'h00, 1'b1, 0, 8'h34);
        tpm_cycle(1'b1, 1'b1, 16'h0024, 8'h5A, 1'b1, 2, 8'h00);

        // Non-TPM start nibble: ignored.
        tick(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R2 other start");
        for (int k = 0; k < 10; k++)
            tick(1'b1, 4'h2, 1'b1, 1'b0, 4'h0, 1'b0, "R2 other start ignored");
        // TPM start with an unknown direction nibble.
        tick(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R2 start");
        tick(1'b1, 4'h4, 1'b0, 1'b0, 4'h0, 1'b0, "R2 bad direction");
        for (int k = 0; k < 10; k++)
            tick(1'b1, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0, "R2 bad direction ignored");
        // Start pattern while framing is high.
        tick(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R2 no frame");
        for (int k = 0; k < 10; k++)
            tick(1'b1, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0, "R2 no frame ignored");

        // Abort during the address phase carrying a new start.
        tick(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R2 start");
        tick(1'b1, 4'h2, 1'b0, 1'b0, 4'h0, 1'b0, "R2 direction");
        tick(1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R3 address nibble");
        tick(1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R3 address nibble");
        tick(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R11 restart");
        tpm_cycle(1'b0, 1'b0, 16'h1234, 8'h00, 1'b1, 1, 8'hC9);

        // Abort while waiting in sync.
        acc_ok = 1'b1;
        tick(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, "R2 start");
        tick(1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R2 direction");
        for (int i = 0; i < 4; i++)
            tick(1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R3 address nibble");
        tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R12 host turnaround");
        tick(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R12 host turnaround");
        tick(1'b1, 4'hF, 1'b0, 1'b1, 4'h6, 1'b1, "R5 long wait");
        tick(1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R11 abort in sync");
        tick(1'b1, 4'hF, 1'b1, 1'b0, 4'h0, 1'b0, "R11 idle after abort");
        tick(1'b1, 4'hF, 1'b1, 1'b0, 4'h0, 1'b0, "R11 idle after abort");

        // Service resumes normally.
        tpm_cycle(1'b1, 1'b0, 16'h0000, 8'h00, 1'b1, 0, 8'h6B);

        while (expq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule